// File: doc/BRIEF.md
# Character Row Vertical Sequencer

This block produces the vertical layout of a text overlay. A rising edge on vertical sync restarts a line counter. The counter then counts rising edges of horizontal sync until it reaches a programmable start line. From that line on, the block walks through the character rows one scan line at a time. For each line it reports the row being drawn and the dot line inside the glyph. Each glyph dot line is repeated 1 to 4 times, set by that row's own vertical size.

A three-bit spacing code can split the rows into an upper and a lower group. The two groups are separated by one blank spacer row. During the spacer row the display area stays open but no characters are shown. The horizontal pixel logic uses the flags, the row index, the dot line and the row's base word address to fetch and draw glyphs. Configuration inputs are expected to stay stable during a frame and may change around a vertical sync.

Top module: `ovl_vseq`

## Requirements
- R1: Out of reset, and until the first rising edge of `vsync_i`, both flags are low and the row index, dot line and base address all read zero. Horizontal sync pulses do not change this.
- R2: After a rising edge of `vsync_i`, the display becomes active on the clock of the `vstart_i`-th rising edge of `hsync_i`, showing row 0 and dot line 0. A start value of 0 never opens the display.
- R3: A character row lasts 18 dot lines, numbered 0 to 17. Each dot line is held for N rising edges of `hsync_i`, where the 2-bit size code gives 00 = 1, 01 = 2, 10 = 3, 11 = 4.
- R4: Row 0 takes its size from `first_hi_i` when `row_sel_i[0]` is 1 and from `first_lo_i` when it is 0. Every other row r takes its size from `rest_hi_i` or `rest_lo_i`, chosen by `row_sel_i[r]` in the same way.
- R5: The spacing code `space_i` sets the layout as rows-before-gap, rows-after-gap: 000 gives 12 rows with no spacer, 001 gives 1 and 10, 010 gives 2 and 8, 011 gives 3 and 6, 100 gives 4 and 4, 101 gives 5 and 2, and 110 gives 6 and 6. Rows after the spacer keep counting the row index from where the upper group stopped.
- R6: During the spacer row, `disp_active_o` is high and `row_active_o` is low. The row index shows the row that follows the spacer. The dot line runs 0 to 17, repeated with the size N of that following row.
- R7: Spacing code 111 gives the same layout as 110.
- R8: After the last row's final scan line, `disp_active_o` stays low and the row index and dot line read zero until the next rising edge of `vsync_i`.
- R9: A rising edge of `vsync_i` restarts the sequence at any point, even in the middle of a displayed frame. The flags are low on the following clock.
- R10: `row_base_o` always equals the row index times 24, which is the word address of column 0 of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync; its rising edge advances one scan line |
| vsync_i | input | 1 | Vertical sync; its rising edge restarts the frame |
| vstart_i | input | 10 | Start line, counted in horizontal sync edges |
| space_i | input | 3 | Spacing code that selects the row layout |
| row_sel_i | input | 12 | Size select bit for each row; bit r belongs to row r |
| first_lo_i | input | 2 | Size code for row 0 when its select bit is 0 |
| first_hi_i | input | 2 | Size code for row 0 when its select bit is 1 |
| rest_lo_i | input | 2 | Size code for rows 1 to 11 when their select bit is 0 |
| rest_hi_i | input | 2 | Size code for rows 1 to 11 when their select bit is 1 |
| disp_active_o | output | 1 | High from the start line to the end of the last row |
| row_active_o | output | 1 | High while a character row (not the spacer) is drawn |
| row_o | output | 4 | Current row index, 0 to 11 |
| dot_o | output | 5 | Dot line inside the glyph, 0 to 17 |
| row_base_o | output | 9 | Word address of column 0 of the current row |

## Verification
The bench targets the off-by-one cases around the start line: start value 1, where the very first horizontal edge opens the display, and start value 0, which must never open it. A counter that compares before incrementing would open the display one line late or early, and one that wraps would eventually open it on a zero start. The spacer row is checked for its height and its reported row. A design that sized the spacer from the row before it, or that advanced the row index across the spacer, would drift out of step for the whole lower group. The bench also covers code 111, a restart by vertical sync in the middle of a frame, and the idle stretch after the last row. A design that wrapped back to row 0 after the last row would draw the screen twice.

// File: rtl/ovl_vseq_pkg.sv
package ovl_vseq_pkg;
   localparam int unsigned DEF_ROWS    = 12;
   localparam int unsigned DEF_COLS    = 24;
   localparam int unsigned DEF_GLYPH_H = 18;
   localparam int unsigned DEF_VP_W    = 10;
   localparam int unsigned DEF_SZ_W    = 2;
   localparam int unsigned SPACE_W     = 3;

   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } vseq_phase_e;
endpackage

// File: rtl/ovl_vseq_edge.sv
module ovl_vseq_edge #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] lvl_q;

   initial assert (W >= 1) else $error("edge width must be positive");

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/ovl_vseq_layout.sv
module ovl_vseq_layout
   import ovl_vseq_pkg::*;
#(
   parameter int unsigned ROWS = DEF_ROWS,
   localparam int unsigned RW  = $clog2(ROWS)
) (
   input  logic [SPACE_W-1:0] space_i,
   output logic               gap_en_o,
   output logic [RW-1:0]      gap_after_o,
   output logic [RW-1:0]      last_row_o
);
   localparam int unsigned HALF = ROWS / 2;

   initial assert (ROWS >= 12 && (ROWS % 2) == 0)
      else $error("layout needs an even row count of at least 12");

   always_comb begin
      gap_en_o    = 1'b0;
      gap_after_o = '0;
      last_row_o  = RW'(ROWS - 1);
      if (space_i == '0) begin
         gap_en_o = 1'b0;
      end else if (space_i >= 3'd6) begin
         // codes 110 and 111: two equal halves
         gap_en_o    = 1'b1;
         gap_after_o = RW'(HALF - 1);
         last_row_o  = RW'(ROWS - 1);
      end else begin
         // code c: c rows, spacer, ROWS-2c rows
         gap_en_o    = 1'b1;
         gap_after_o = RW'(space_i) - RW'(1);
         last_row_o  = RW'(ROWS - 1) - RW'(space_i);
      end
   end
endmodule

// File: rtl/ovl_vseq_size.sv
module ovl_vseq_size
   import ovl_vseq_pkg::*;
#(
   parameter int unsigned ROWS = DEF_ROWS,
   parameter int unsigned SZ_W = DEF_SZ_W,
   localparam int unsigned RW  = $clog2(ROWS)
) (
   input  logic [ROWS-1:0] row_sel_i,
   input  logic [SZ_W-1:0] first_lo_i,
   input  logic [SZ_W-1:0] first_hi_i,
   input  logic [SZ_W-1:0] rest_lo_i,
   input  logic [SZ_W-1:0] rest_hi_i,
   input  logic [RW-1:0]   row_i,
   output logic [SZ_W-1:0] code_o
);
   logic [SZ_W-1:0] code_a [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (r == 0) begin : g_first
         assign code_a[r] = row_sel_i[r] ? first_hi_i : first_lo_i;
      end else begin : g_rest
         assign code_a[r] = row_sel_i[r] ? rest_hi_i : rest_lo_i;
      end
   end

   always_comb begin
      code_o = '0;
      for (int r = 0; r < ROWS; r++)
         if (row_i == RW'(r)) code_o = code_a[r];
   end
endmodule

// File: rtl/ovl_vseq.sv
module ovl_vseq
   import ovl_vseq_pkg::*;
#(
   parameter int unsigned ROWS    = DEF_ROWS,
   parameter int unsigned COLS    = DEF_COLS,
   parameter int unsigned GLYPH_H = DEF_GLYPH_H,
   parameter int unsigned VP_W    = DEF_VP_W,
   parameter int unsigned SZ_W    = DEF_SZ_W,
   localparam int unsigned RW     = $clog2(ROWS),
   localparam int unsigned DOT_W  = $clog2(GLYPH_H),
   localparam int unsigned RA_W   = $clog2(ROWS * COLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hsync_i,
   input  logic               vsync_i,
   input  logic [VP_W-1:0]    vstart_i,
   input  logic [SPACE_W-1:0] space_i,
   input  logic [ROWS-1:0]    row_sel_i,
   input  logic [SZ_W-1:0]    first_lo_i,
   input  logic [SZ_W-1:0]    first_hi_i,
   input  logic [SZ_W-1:0]    rest_lo_i,
   input  logic [SZ_W-1:0]    rest_hi_i,
   output logic               disp_active_o,
   output logic               row_active_o,
   output logic [RW-1:0]      row_o,
   output logic [DOT_W-1:0]   dot_o,
   output logic [RA_W-1:0]    row_base_o
);
   localparam logic [VP_W-1:0]  LCNT_MAX = '1;
   localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(GLYPH_H - 1);
   localparam logic [RA_W-1:0]  COLS_L   = RA_W'(COLS);

   initial assert (GLYPH_H >= 2 && COLS >= 1 && VP_W >= 2 && SZ_W >= 1)
      else $error("ovl_vseq parameter out of range");

   logic [1:0]      rise;
   logic            hs_rise, vs_rise;
   logic            gap_en;
   logic [RW-1:0]   gap_after, last_row;
   logic [SZ_W-1:0] cur_code;

   vseq_phase_e     phase_q;
   logic [VP_W-1:0] lcnt_q;
   logic [VP_W:0]   lnext;
   logic [RW-1:0]   row_q;
   logic [DOT_W-1:0] dot_q;
   logic [SZ_W-1:0] rep_q;
   logic            gap_q;

   ovl_vseq_edge #(.W(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({vsync_i, hsync_i}),
      .rise_o (rise)
   );
   assign hs_rise = rise[0];
   assign vs_rise = rise[1];

   ovl_vseq_layout #(.ROWS(ROWS)) u_layout (
      .space_i     (space_i),
      .gap_en_o    (gap_en),
      .gap_after_o (gap_after),
      .last_row_o  (last_row)
   );

   ovl_vseq_size #(.ROWS(ROWS), .SZ_W(SZ_W)) u_size (
      .row_sel_i  (row_sel_i),
      .first_lo_i (first_lo_i),
      .first_hi_i (first_hi_i),
      .rest_lo_i  (rest_lo_i),
      .rest_hi_i  (rest_hi_i),
      .row_i      (row_q),
      .code_o     (cur_code)
   );

   assign lnext = {1'b0, lcnt_q} + (VP_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_DONE;
         lcnt_q  <= '0;
         row_q   <= '0;
         dot_q   <= '0;
         rep_q   <= '0;
         gap_q   <= 1'b0;
      end else if (vs_rise) begin
         phase_q <= PH_WAIT;
         lcnt_q  <= '0;
         row_q   <= '0;
         dot_q   <= '0;
         rep_q   <= '0;
         gap_q   <= 1'b0;
      end else if (hs_rise) begin
         unique case (phase_q)
            PH_WAIT: begin
               if (lcnt_q != LCNT_MAX) lcnt_q <= lnext[VP_W-1:0];
               if (lnext == {1'b0, vstart_i}) phase_q <= PH_RUN;
            end
            PH_RUN: begin
               if (rep_q != cur_code) begin
                  rep_q <= rep_q + SZ_W'(1);
               end else begin
                  rep_q <= '0;
                  if (dot_q != DOT_LAST) begin
                     dot_q <= dot_q + DOT_W'(1);
                  end else begin
                     dot_q <= '0;
                     if (gap_q) begin
                        gap_q <= 1'b0;
                     end else if (row_q == last_row) begin
                        phase_q <= PH_DONE;
                        row_q   <= '0;
                     end else begin
                        row_q <= row_q + RW'(1);
                        gap_q <= gap_en && (row_q == gap_after);
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign disp_active_o = (phase_q == PH_RUN);
   assign row_active_o  = (phase_q == PH_RUN) && !gap_q;
   assign row_o         = row_q;
   assign dot_o         = dot_q;
   assign row_base_o    = RA_W'(row_q) * COLS_L;

   p_dot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dot_o <= DOT_LAST);

   p_dot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_active_o && $past(disp_active_o) && !$stable(dot_o)) |-> $past(hs_rise));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_active_o) |-> ($past(hs_rise) && row_o == '0 && dot_o == '0));

   p_rowact_in_disp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      row_active_o |-> disp_active_o);

   p_vs_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (!disp_active_o && !row_active_o));

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disp_active_o) |-> (row_o == '0 && dot_o == '0));
endmodule

// File: tb/ovl_vseq_bench.sv
module ovl_vseq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HP         = 4;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0, vsync = 1'b0;
   logic [9:0]  vstart = '0;
   logic [2:0]  space = '0;
   logic [11:0] rsel = '0;
   logic [1:0]  f_lo = '0, f_hi = '0, r_lo = '0, r_hi = '0;
   logic        disp, ract;
   logic [3:0]  row;
   logic [4:0]  dot;
   logic [8:0]  base;

   int n_checks = 0, n_fail = 0, cycles = 0;
   string cur_tag = "R1";
   int exp_q[$];
   int cur = 0;
   bit vprev = 0, hprev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ovl_vseq u_ovl_vseq (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .vstart_i(vstart), .space_i(space), .row_sel_i(rsel),
      .first_lo_i(f_lo), .first_hi_i(f_hi), .rest_lo_i(r_lo), .rest_hi_i(r_hi),
      .disp_active_o(disp), .row_active_o(ract), .row_o(row), .dot_o(dot),
      .row_base_o(base)
   );

   task automatic check(input bit ok, input string what, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at t=%0t", what, act, expv, $time);
      end
   endtask

   function automatic int size_of(input int r);
      if (r == 0) return rsel[0] ? int'(f_hi) : int'(f_lo);
      return rsel[r] ? int'(r_hi) : int'(r_lo);
   endfunction

   function automatic int pack(input int a, input int ra, input int r, input int d);
      return (a << 16) | (ra << 15) | (r << 8) | d;
   endfunction

   // expected scan lines of one frame, one entry per horizontal edge
   function automatic void build_frame();
      int top, bot, n;
      bit gap;
      exp_q.delete();
      if (vstart == 0) return;
      for (int i = 1; i < int'(vstart); i++) exp_q.push_back(0);
      case (space)
         3'd0: begin top = 12; bot = 0; gap = 0; end
         3'd6, 3'd7: begin top = 6; bot = 6; gap = 1; end
         default: begin top = int'(space); bot = 12 - 2*int'(space); gap = 1; end
      endcase
      for (int r = 0; r < top + bot; r++) begin
         if (gap && r == top) begin
            n = size_of(r) + 1;
            for (int d = 0; d < 18; d++)
               for (int k = 0; k < n; k++) exp_q.push_back(pack(1, 0, r, d));
         end
         n = size_of(r) + 1;
         for (int d = 0; d < 18; d++)
            for (int k = 0; k < n; k++) exp_q.push_back(pack(1, 1, r, d));
      end
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (vsync && !vprev) begin
            build_frame();
            cur = 0;
         end else if (hsync && !hprev) begin
            cur = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
         end
         vprev = vsync;
         hprev = hsync;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(disp == cur[16], {cur_tag, " display-active"}, disp, cur[16]);
         check(ract == cur[15], {cur_tag, " row-active"}, ract, cur[15]);
         check(int'(row) == ((cur >> 8) & 15), {cur_tag, " row index"}, row, (cur >> 8) & 15);
         check(int'(dot) == (cur & 31), {cur_tag, " dot line"}, dot, cur & 31);
         check(int'(base) == int'(row) * 24, "R10 row base address", base, int'(row) * 24);
      end
      if (cycles > WATCHDOG) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic lines(input int nl);
      for (int i = 0; i < nl; i++) begin
         hsync = 1'b1;
         @(negedge clk) hsync = 1'b0;
         repeat (HP - 1) @(negedge clk);
      end
   endtask

   task automatic frame(input int vp, input int sp, input int sel, input int fl, input int fh,
                        input int rl, input int rh, input int nl, input string tag);
      @(negedge clk);
      cur_tag = tag;
      vstart = 10'(vp); space = 3'(sp); rsel = 12'(sel);
      f_lo = 2'(fl); f_hi = 2'(fh); r_lo = 2'(rl); r_hi = 2'(rh);
      vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
      repeat (2) @(negedge clk);
      lines(nl);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check(disp == 0 && ract == 0, "R1 flags in reset", {disp, ract}, 0);
      check(row == 0 && dot == 0 && base == 0, "R1 counters in reset", {row, dot}, 0);
      rst_n = 1'b1;
      cur_tag = "R1";
      lines(20);
      // R3: all rows single-height, no spacer
      frame(3, 0, 12'h000, 0, 3, 0, 3, 240, "R3");
      // R4: mixed selects pick different codes
      frame(1, 0, 12'b1010_0101_0011, 1, 3, 0, 2, 620, "R4");
      // R5: 3 + spacer + 6
      frame(5, 3, 12'b0000_1100_1001, 2, 0, 1, 0, 420, "R5");
      // R6: spacer after row 0 takes row 1 height (4)
      frame(2, 1, 12'b0000_0000_0010, 0, 1, 0, 3, 300, "R6");
      // R5: other layouts
      frame(4, 2, 12'h0F0, 0, 0, 0, 1, 280, "R5");
      frame(4, 4, 12'h000, 0, 0, 1, 0, 320, "R5");
      frame(3, 5, 12'h000, 3, 0, 3, 0, 620, "R5");
      // R7: code 111 same as 110
      frame(6, 7, 12'b1000_0100_0001, 1, 2, 0, 1, 440, "R7");
      frame(6, 6, 12'b1000_0100_0001, 1, 2, 0, 1, 440, "R7");
      // R2: start of zero never opens display
      frame(0, 0, 12'h000, 0, 0, 0, 0, 300, "R2");
      // R9: restart mid-frame, then a fresh frame
      frame(2, 0, 12'hFFF, 0, 2, 0, 2, 150, "R9");
      frame(2, 3, 12'h000, 0, 1, 0, 1, 120, "R9");
      // R8: end of frame then long idle stretch
      frame(1, 0, 12'h000, 0, 0, 0, 0, 400, "R8");
      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule